// File: doc/BRIEF.md
# Serial Link Out-of-Band Bring-Up Controller

This block sits on the host side between an abstract serial transceiver and the link layer. It brings up a serial storage link from cold. It sends a reset burst sequence and waits for the device's init reply. It then exchanges wake sequences and drives a training pattern until the device returns ALIGN. After that it sends ALIGN until SYNC arrives, and then declares the link ready. Each out-of-band sequence is six bursts with idle gaps between them. Reset and init use a long gap and wake uses a short gap. Burst and gap widths are parameters counted in clock cycles. Received sequences are classified only by the length of their gaps, within a tolerance window.

Negotiation starts at the fastest rate (Gen3). If ALIGN does not arrive in time, the controller drops one generation and raises a rate-change request to an external reconfiguration port. It holds that request until the port acknowledges it, then starts again from reset. At Gen1 it keeps retrying without any request. Once the link is up, the link layer can put it into the partial or slumber power state. Either a host wake request or a device wake sequence brings it back through a wake exchange. An unsolicited init from the device drops the link and restarts bring-up. A status code is driven on every cycle.

Top module: `sata_oob_ctrl`

## Requirements
- R1: After reset release the controller emits a reset sequence on `tx_oob_burst`: six bursts, each BURST_LEN cycles high, separated by GAP_LONG low cycles. `tx_elec_idle` is high whenever no burst or pattern is being sent.
- R2: After a device init sequence is recognised, the controller emits a wake sequence: six bursts of BURST_LEN cycles separated by GAP_SHORT low cycles.
- R3: On `rx_burst`, six bursts whose five gaps each lie within GAP_TOL of GAP_LONG are recognised as init. Gaps within GAP_TOL of GAP_SHORT are recognised as wake. A gap outside both windows restarts the count, so neither a short-gap sequence nor a mid-length-gap sequence is taken as init.
- R4: If no init is recognised within INIT_TIMEOUT cycles of waiting, the reset sequence is sent again.
- R5: After the device's wake, `tx_pattern` is 1 (D10.2) until `rx_align_det`, then 2 (ALIGN) until `rx_sync_det`, then 3 (data) with `link_ready` high. `tx_pattern` is 0 when no pattern is sent.
- R6: `rate_sel` starts at 2 (Gen3; 1 is Gen2, 0 is Gen1). If ALIGN or SYNC does not arrive within ALIGN_TIMEOUT cycles, `rate_sel` drops by one and `rate_req` rises. Both hold until `rate_ack`, and then the reset sequence restarts.
- R7: A timeout at Gen1 raises no `rate_req`, keeps `rate_sel` at 0 and restarts with the reset sequence.
- R8: While ready, a pulse on `pm_partial_req` or `pm_slumber_req` moves the link to the partial (status 5) or slumber (status 6) state. In that state `link_ready` is low and `tx_elec_idle` is high.
- R9: A power state is left by `pm_wake_req` or by a device wake sequence. Either way the controller sends a wake sequence and resumes D10.2 at the same rate. A host-initiated exit waits for the device's wake first; a device-initiated exit does not wait again.
- R10: A device init recognised while ready, partial or slumber drops `link_ready` and restarts with the reset sequence (status 0).
- R11: `link_status` reports the phase on every cycle: 0 sending reset, 1 awaiting init, 2 wake exchange, 3 speed negotiation, 4 ready, 5 partial, 6 slumber, 7 rate change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_burst | input | 1 | Receiver sees burst activity (squelch open) |
| rx_align_det | input | 1 | ALIGN primitives received at the current rate |
| rx_sync_det | input | 1 | SYNC primitives received |
| pm_partial_req | input | 1 | Link layer asks for the partial power state |
| pm_slumber_req | input | 1 | Link layer asks for the slumber power state |
| pm_wake_req | input | 1 | Link layer asks to leave a power state |
| rate_ack | input | 1 | Reconfiguration port has applied `rate_sel` |
| tx_oob_burst | output | 1 | Transmit an out-of-band burst |
| tx_elec_idle | output | 1 | Transmitter held in electrical idle |
| tx_pattern | output | 2 | 0 none, 1 D10.2, 2 ALIGN, 3 link data |
| rate_sel | output | 2 | 0 Gen1, 1 Gen2, 2 Gen3 |
| rate_req | output | 1 | Rate change request, held until `rate_ack` |
| link_ready | output | 1 | Link is up and passing data |
| link_status | output | 3 | Phase code per R11 |

## Verification
On every cycle the assertions check the following. Each transmitted sequence has exactly six bursts, none wider than BURST_LEN. The detector never flags init and wake together. The rate only ever steps down by one and stays stable while a request waits for acknowledgement. No request is raised at Gen1. The ready flag rises only after SYNC and falls only after an init or a power request. The exact gap lengths, the timeout retry, the classification of good and malformed received sequences, and the two different wake exits from power states are shown only by the bench's scenarios, which measure the bursts on the pins and drive device sequences.

// File: rtl/oob_link_pkg.sv
package oob_link_pkg;

    localparam int OOB_BURSTS = 6;

    typedef enum logic [1:0] {
        RATE_G1 = 2'd0,
        RATE_G2 = 2'd1,
        RATE_G3 = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        PAT_NONE  = 2'd0,
        PAT_D10_2 = 2'd1,
        PAT_ALIGN = 2'd2,
        PAT_DATA  = 2'd3
    } pat_e;

    typedef enum logic [2:0] {
        LS_RESET   = 3'd0,
        LS_AWAIT   = 3'd1,
        LS_WAKE    = 3'd2,
        LS_NEGO    = 3'd3,
        LS_READY   = 3'd4,
        LS_PARTIAL = 3'd5,
        LS_SLUMBER = 3'd6,
        LS_RATE    = 3'd7
    } status_e;

    typedef enum logic [3:0] {
        F_TX_RST, F_WAIT_INIT, F_TX_WAKE, F_WAIT_WAKE, F_D10,
        F_ALIGN, F_READY, F_PARTIAL, F_SLUMBER, F_RATE
    } fsm_e;

    function automatic status_e status_of(fsm_e s);
        case (s)
            F_TX_RST:                status_of = LS_RESET;
            F_WAIT_INIT:             status_of = LS_AWAIT;
            F_TX_WAKE, F_WAIT_WAKE:  status_of = LS_WAKE;
            F_D10, F_ALIGN:          status_of = LS_NEGO;
            F_READY:                 status_of = LS_READY;
            F_PARTIAL:               status_of = LS_PARTIAL;
            F_SLUMBER:               status_of = LS_SLUMBER;
            default:                 status_of = LS_RATE;
        endcase
    endfunction

    function automatic rate_e rate_down(rate_e r);
        rate_down = (r == RATE_G1) ? RATE_G1 : rate_e'(2'(r) - 2'd1);
    endfunction

endpackage

// File: rtl/oob_tx_seq.sv
module oob_tx_seq
    import oob_link_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int GAP_LONG  = 12,
    parameter int GAP_SHORT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_gap,
    output logic burst,
    output logic done
);
    localparam int MAXLEN = (BURST_LEN > GAP_LONG) ? BURST_LEN : GAP_LONG;
    localparam int CW     = $clog2(MAXLEN + 1);

    logic          busy;
    logic          long_q;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [CW-1:0] gap_lim;

    assign gap_lim = long_q ? CW'(GAP_LONG - 1) : CW'(GAP_SHORT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            burst  <= 1'b0;
            done   <= 1'b0;
            long_q <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    burst  <= 1'b1;
                    cnt    <= '0;
                    idx    <= '0;
                    long_q <= long_gap;
                end
            end else if (burst) begin
                if (cnt == CW'(BURST_LEN - 1)) begin
                    cnt   <= '0;
                    burst <= 1'b0;
                    if (idx == 3'(OOB_BURSTS - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == gap_lim) begin
                    cnt   <= '0;
                    burst <= 1'b1;
                    idx   <= idx + 3'd1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // checker state: burst rises in the current sequence and current run width
    logic          chk_burst_d;
    logic [3:0]    chk_rises;
    logic [CW:0]   chk_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_burst_d <= 1'b0;
            chk_rises   <= '0;
            chk_run     <= '0;
        end else begin
            chk_burst_d <= burst;
            if (!busy)
                chk_rises <= '0;
            else if (burst && !chk_burst_d)
                chk_rises <= chk_rises + 4'd1;
            chk_run <= burst ? chk_run + 1'b1 : '0;
        end
    end

    assert_burst_only_busy_R1: assert property (@(posedge clk) disable iff (rst)
        burst |-> busy);
    assert_six_bursts_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_rises == 4'(OOB_BURSTS)));
    assert_burst_width_R1: assert property (@(posedge clk) disable iff (rst)
        burst |-> (chk_run < (CW+1)'(BURST_LEN)));

endmodule

// File: rtl/oob_rx_det.sv
module oob_rx_det #(
    parameter int GAP_LONG  = 12,
    parameter int GAP_SHORT = 4,
    parameter int GAP_TOL   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_burst,
    output logic init_det,
    output logic wake_det
);
    localparam int GSAT = GAP_LONG + GAP_TOL + 1;
    localparam int GW   = $clog2(GSAT + 1);

    logic          prev;
    logic [GW-1:0] gcnt;
    logic [2:0]    lcnt, scnt;
    logic          rise, in_long, in_short;

    assign rise     = rx_burst && !prev;
    assign in_long  = (gcnt >= GW'(GAP_LONG - GAP_TOL))  && (gcnt <= GW'(GAP_LONG + GAP_TOL));
    assign in_short = (gcnt >= GW'(GAP_SHORT - GAP_TOL)) && (gcnt <= GW'(GAP_SHORT + GAP_TOL));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= 1'b0;
            gcnt     <= GW'(GSAT);
            lcnt     <= '0;
            scnt     <= '0;
            init_det <= 1'b0;
            wake_det <= 1'b0;
        end else begin
            prev     <= rx_burst;
            init_det <= 1'b0;
            wake_det <= 1'b0;
            if (rx_burst)
                gcnt <= '0;
            else if (gcnt != GW'(GSAT))
                gcnt <= gcnt + 1'b1;
            if (rise) begin
                if (in_long) begin
                    scnt <= '0;
                    if (lcnt == 3'd4) begin
                        init_det <= 1'b1;
                        lcnt     <= '0;
                    end else begin
                        lcnt <= lcnt + 3'd1;
                    end
                end else if (in_short) begin
                    lcnt <= '0;
                    if (scnt == 3'd4) begin
                        wake_det <= 1'b1;
                        scnt     <= '0;
                    end else begin
                        scnt <= scnt + 3'd1;
                    end
                end else begin
                    lcnt <= '0;
                    scnt <= '0;
                end
            end
        end
    end

    assert_det_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_det, wake_det}));
    assert_det_needs_burst_R3: assert property (@(posedge clk) disable iff (rst)
        (init_det || wake_det) |-> $past(rx_burst));

endmodule

// File: rtl/sata_oob_ctrl.sv
module sata_oob_ctrl
    import oob_link_pkg::*;
#(
    parameter int BURST_LEN     = 4,
    parameter int GAP_LONG      = 12,
    parameter int GAP_SHORT     = 4,
    parameter int GAP_TOL       = 1,
    parameter int INIT_TIMEOUT  = 200,
    parameter int ALIGN_TIMEOUT = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_burst,
    input  logic       rx_align_det,
    input  logic       rx_sync_det,
    input  logic       pm_partial_req,
    input  logic       pm_slumber_req,
    input  logic       pm_wake_req,
    input  logic       rate_ack,
    output logic       tx_oob_burst,
    output logic       tx_elec_idle,
    output logic [1:0] tx_pattern,
    output logic [1:0] rate_sel,
    output logic       rate_req,
    output logic       link_ready,
    output logic [2:0] link_status
);
    localparam int TMAX = (INIT_TIMEOUT > ALIGN_TIMEOUT) ? INIT_TIMEOUT : ALIGN_TIMEOUT;
    localparam int TW   = $clog2(TMAX + 1);

    fsm_e          state, nxt;
    rate_e         rate_q;
    pat_e          pat;
    logic [TW-1:0] tmr;
    logic          start_q, wake_pend;
    logic          seq_done, init_det, wake_det;
    logic          init_to, align_to;
    fsm_e          fallback;

    oob_tx_seq #(.BURST_LEN(BURST_LEN), .GAP_LONG(GAP_LONG), .GAP_SHORT(GAP_SHORT)) u_tx (
        .clk(clk), .rst(rst), .start(start_q), .long_gap(state == F_TX_RST),
        .burst(tx_oob_burst), .done(seq_done));

    oob_rx_det #(.GAP_LONG(GAP_LONG), .GAP_SHORT(GAP_SHORT), .GAP_TOL(GAP_TOL)) u_rx (
        .clk(clk), .rst(rst), .rx_burst(rx_burst),
        .init_det(init_det), .wake_det(wake_det));

    assign init_to  = (tmr == TW'(INIT_TIMEOUT - 1));
    assign align_to = (tmr == TW'(ALIGN_TIMEOUT - 1));
    assign fallback = (rate_q == RATE_G1) ? F_TX_RST : F_RATE;

    always_comb begin
        nxt = state;
        unique case (state)
            F_TX_RST:    if (seq_done) nxt = F_WAIT_INIT;
            F_WAIT_INIT: if (init_det) nxt = F_TX_WAKE;
                         else if (init_to) nxt = F_TX_RST;
            F_TX_WAKE:   if (seq_done) nxt = F_WAIT_WAKE;
            F_WAIT_WAKE: if (wake_det || wake_pend) nxt = F_D10;
                         else if (init_to) nxt = F_TX_RST;
            F_D10:       if (rx_align_det) nxt = F_ALIGN;
                         else if (align_to) nxt = fallback;
            F_ALIGN:     if (rx_sync_det) nxt = F_READY;
                         else if (align_to) nxt = fallback;
            F_READY:     if (init_det) nxt = F_TX_RST;
                         else if (pm_partial_req) nxt = F_PARTIAL;
                         else if (pm_slumber_req) nxt = F_SLUMBER;
            F_PARTIAL, F_SLUMBER:
                         if (init_det) nxt = F_TX_RST;
                         else if (pm_wake_req || wake_det) nxt = F_TX_WAKE;
            F_RATE:      if (rate_ack) nxt = F_TX_RST;
            default:     nxt = F_TX_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= F_TX_RST;
            rate_q    <= RATE_G3;
            tmr       <= '0;
            start_q   <= 1'b1;
            wake_pend <= 1'b0;
        end else begin
            state   <= nxt;
            tmr     <= (nxt != state) ? '0 : tmr + 1'b1;
            start_q <= (nxt != state) && (nxt == F_TX_RST || nxt == F_TX_WAKE);
            if (state != F_RATE && nxt == F_RATE)
                rate_q <= rate_down(rate_q);
            if (nxt == F_TX_RST || (state == F_WAIT_WAKE && nxt != state))
                wake_pend <= 1'b0;
            else if (wake_det && (state == F_TX_WAKE || state == F_PARTIAL || state == F_SLUMBER))
                wake_pend <= 1'b1;
        end
    end

    always_comb begin
        case (state)
            F_D10:   pat = PAT_D10_2;
            F_ALIGN: pat = PAT_ALIGN;
            F_READY: pat = PAT_DATA;
            default: pat = PAT_NONE;
        endcase
    end

    assign tx_pattern   = pat;
    assign tx_elec_idle = !tx_oob_burst && (pat == PAT_NONE);
    assign rate_sel     = rate_q;
    assign rate_req     = (state == F_RATE);
    assign link_ready   = (state == F_READY);
    assign link_status  = status_of(state);

    assert_ready_after_sync_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ready) |-> $past(rx_sync_det));
    assert_ready_drop_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(link_ready) |-> $past(init_det || pm_partial_req || pm_slumber_req));
    assert_rate_steps_down_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_sel) != rate_sel) |-> (rate_sel == 2'($past(rate_sel) - 2'd1)));
    assert_rate_req_held_R6: assert property (@(posedge clk) disable iff (rst)
        (rate_req && !rate_ack) |=> (rate_req && $stable(rate_sel)));
    assert_gen1_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_sel) == 2'd0 && !$past(rate_req)) |-> !rate_req);
    assert_idle_in_power_R8: assert property (@(posedge clk) disable iff (rst)
        (link_status == 3'd5 || link_status == 3'd6) |-> (tx_elec_idle && !link_ready));

endmodule

// File: tb/sim_sata_oob_ctrl.sv
module sim_sata_oob_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BL = 4, GL = 12, GS = 4, TOL = 1, INIT_TO = 200, ALIGN_TO = 100;

    logic clk = 1'b0, rst = 1'b1;
    logic rx_burst = 0, rx_align_det = 0, rx_sync_det = 0;
    logic pm_partial_req = 0, pm_slumber_req = 0, pm_wake_req = 0, rate_ack = 0;
    logic tx_oob_burst, tx_elec_idle, rate_req, link_ready;
    logic [1:0] tx_pattern, rate_sel;
    logic [2:0] link_status;

    int n_chk = 0, n_fail = 0;
    int n_b = 0, b_run = 0, gap_run = 0, last_blen = 0, last_gap = 0;
    logic prev_b = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sata_oob_ctrl #(.BURST_LEN(BL), .GAP_LONG(GL), .GAP_SHORT(GS), .GAP_TOL(TOL),
                    .INIT_TIMEOUT(INIT_TO), .ALIGN_TIMEOUT(ALIGN_TO)) u0 (
        .clk(clk), .rst(rst), .rx_burst(rx_burst), .rx_align_det(rx_align_det),
        .rx_sync_det(rx_sync_det), .pm_partial_req(pm_partial_req),
        .pm_slumber_req(pm_slumber_req), .pm_wake_req(pm_wake_req), .rate_ack(rate_ack),
        .tx_oob_burst(tx_oob_burst), .tx_elec_idle(tx_elec_idle), .tx_pattern(tx_pattern),
        .rate_sel(rate_sel), .rate_req(rate_req), .link_ready(link_ready),
        .link_status(link_status));

    // transmit burst monitor
    always @(posedge clk) begin
        if (tx_oob_burst) begin
            if (!prev_b) begin
                n_b = n_b + 1;
                if (n_b > 1) last_gap = gap_run;
                b_run = 0;
            end
            b_run = b_run + 1;
            last_blen = b_run;
        end else begin
            if (prev_b) gap_run = 0;
            gap_run = gap_run + 1;
        end
        prev_b = tx_oob_burst;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_status(input string tag, input int s, input int maxc);
        for (int i = 0; i < maxc && link_status != 3'(s); i++) @(negedge clk);
        chk(tag, link_status, s);
    endtask

    task automatic dev_send(input int gap);
        for (int b = 0; b < 6; b++) begin
            rx_burst = 1'b1;
            repeat (BL) @(negedge clk);
            rx_burst = 1'b0;
            if (b < 5) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; @(negedge clk); sig = 1'b0;
    endtask

    task automatic bring_to_nego();
        expect_status("R4 await init", 1, 400);
        dev_send(GL);
        expect_status("R3 init seen", 2, 6);
        dev_send(GS);
        expect_status("R5 negotiating", 3, 60);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 reset status", link_status, 0);
        chk("R6 start rate Gen3", rate_sel, 2);
        chk("R6 no request", rate_req, 0);
        chk("R5 no pattern", tx_pattern, 0);
        chk("R5 not ready", link_ready, 0);
    endtask

    task automatic t_comreset();
        expect_status("R11 awaiting init", 1, 200);
        chk("R1 burst count", n_b, 6);
        chk("R1 burst width", last_blen, BL);
        chk("R1 long gap", last_gap, GL);
        chk("R1 idle between", tx_elec_idle, 1);
    endtask

    task automatic t_init_timeout();
        n_b = 0;
        expect_status("R4 retry reset", 0, INIT_TO + 10);
        expect_status("R4 awaiting again", 1, 200);
        chk("R4 resent bursts", n_b, 6);
    endtask

    task automatic t_bad_init();
        dev_send(8);
        repeat (3) @(negedge clk);
        chk("R3 mid gap ignored", link_status, 1);
        dev_send(GS);
        repeat (3) @(negedge clk);
        chk("R3 short gap not init", link_status, 1);
    endtask

    task automatic t_wake_exchange();
        expect_status("R4 await init", 1, 400);
        n_b = 0;
        dev_send(GL);
        expect_status("R3 init seen", 2, 6);
        repeat (50) @(negedge clk);
        chk("R2 wake bursts", n_b, 6);
        chk("R2 short gap", last_gap, GS);
        chk("R2 burst width", last_blen, BL);
        chk("R11 still in wake", link_status, 2);
        dev_send(GS);
        expect_status("R5 negotiating", 3, 6);
        chk("R5 D10.2 pattern", tx_pattern, 1);
        chk("R5 not idle", tx_elec_idle, 0);
    endtask

    task automatic t_align_sync();
        rx_align_det = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 ALIGN pattern", tx_pattern, 2);
        rx_sync_det = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 ready", link_ready, 1);
        chk("R11 ready status", link_status, 4);
        chk("R5 data pattern", tx_pattern, 3);
        rx_align_det = 1'b0;
        rx_sync_det  = 1'b0;
    endtask

    task automatic t_partial();
        pulse(pm_partial_req);
        chk("R8 partial status", link_status, 5);
        chk("R8 partial not ready", link_ready, 0);
        chk("R8 partial idle", tx_elec_idle, 1);
        n_b = 0;
        pulse(pm_wake_req);
        expect_status("R9 host wake", 2, 3);
        repeat (50) @(negedge clk);
        chk("R9 wake bursts", n_b, 6);
        chk("R9 waits for device", link_status, 2);
        dev_send(GS);
        expect_status("R9 resume nego", 3, 6);
        chk("R9 same rate", rate_sel, 2);
        t_align_sync();
    endtask

    task automatic t_slumber();
        pulse(pm_slumber_req);
        chk("R8 slumber status", link_status, 6);
        chk("R8 slumber idle", tx_elec_idle, 1);
        n_b = 0;
        dev_send(GS);
        expect_status("R9 device wake", 2, 6);
        expect_status("R9 no second wait", 3, 60);
        chk("R9 host answered wake", n_b, 6);
        t_align_sync();
    endtask

    task automatic t_unsolicited_init();
        dev_send(GL);
        expect_status("R10 restart", 0, 4);
        chk("R10 ready dropped", link_ready, 0);
    endtask

    task automatic t_fallback();
        bring_to_nego();
        expect_status("R6 rate change", 7, ALIGN_TO + 5);
        chk("R6 request", rate_req, 1);
        chk("R6 Gen2", rate_sel, 1);
        repeat (10) @(negedge clk);
        chk("R6 request held", rate_req, 1);
        chk("R6 rate held", rate_sel, 1);
        pulse(rate_ack);
        chk("R6 restart after ack", link_status, 0);
        chk("R6 request cleared", rate_req, 0);
        bring_to_nego();
        expect_status("R6 second drop", 7, ALIGN_TO + 5);
        chk("R6 Gen1", rate_sel, 0);
        pulse(rate_ack);
        bring_to_nego();
        for (int i = 0; i < ALIGN_TO + 5 && link_status == 3'd3; i++) begin
            @(negedge clk);
            if (rate_req) begin
                chk("R7 no request at Gen1", rate_req, 0);
                break;
            end
        end
        chk("R7 retry reset", link_status, 0);
        chk("R7 stays Gen1", rate_sel, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_comreset();
        t_init_timeout();
        t_bad_init();
        t_wake_exchange();
        t_align_sync();
        t_partial();
        t_slumber();
        t_unsolicited_init();
        t_fallback();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule